// File: doc/BRIEF.md
# CAN Channel Status-Change Interrupt Register

This block holds the status word of one CAN controller channel and turns changes in that status into interrupt requests. The protocol engine reports pulses for error-free receptions (with a flag showing whether the frame was stored in a message centre) and for error-free, acknowledged transmissions. It also supplies the live transmit and receive error counts. Two low-power selects drive a wake status bit. The host reads and writes the register through a simple single-cycle port.

Sticky receive and transmit status bits are visible to the host. A separate hidden status-change flag drives the interrupt. The flag is raised by every qualifying event, including an event that arrives when the matching bit is already set. It is also raised by a host write of 1 to a cleared bit, which gives an artificial interrupt. Only a read of the register drops the flag. A 2-bit code reports a status change first, then any message-centre interrupt, and otherwise nothing. The interrupt request is a level output: the flag is gated by the channel, module and global enables, and the result is ORed with the message-centre pending input.

Top module: `can_stat_irq`

## Requirements
- R1: One cycle after the inputs are sampled, `err_lvl` is 1 if `tec` or `rec` is 128 or more, and 0 if both are below 128.
- R2: Any change of `err_lvl`, in either direction, sets the status-change flag in the same cycle when `err_ie` is 1.
- R3: One cycle after the inputs are sampled, `wake_stat` equals `doze OR pwr_down`. A 1-to-0 change of `wake_stat` sets the status-change flag when `stat_ie` is 1. A 0-to-1 change does not set the flag.
- R4: When `autobaud` is 1, an `rx_ok` pulse sets `rx_stat`. When `autobaud` is 0, `rx_ok` sets `rx_stat` only if `rx_stored` is also 1.
- R5: A `tx_ok` pulse sets `tx_stat`.
- R6: The hardware never clears `rx_stat` or `tx_stat`. A host write (bit 4 = receive, bit 3 = transmit) loads the written value, so writing 0 clears the bit. A hardware set in the same cycle as a host write wins over the write.
- R7: Each qualifying reception or transmission sets the status-change flag when `stat_ie` is 1, even if the matching status bit is already 1.
- R8: `int_code` is 2'b01 while the flag is set. Otherwise it is 2'b10 while `mc_pend` is 1, and 2'b00 when neither holds. A `reg_rd` clears the flag at the next edge.
- R9: A host write of 1 to a status bit that is 0 sets the bit and, when `stat_ie` is 1, sets the flag. A write of 1 to a bit that is already 1 does not set the flag.
- R10: If a flag-setting event occurs in the same cycle as `reg_rd`, the flag stays set.
- R11: `irq` = (flag AND `chan_ie` AND `mod_ie` AND `glob_ie`) OR `mc_pend`.
- R12: `reg_rdata` places the error flag at bit 6, wake at bit 5, receive at bit 4 and transmit at bit 3. All other bits read 0.
- R13: `ctl_reset`, like `rst_n`, clears `rx_stat`, `tx_stat` and the flag, and takes priority over every set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| ctl_reset | input | 1 | Controller reset bit, clears the status bits and the flag |
| rx_ok | input | 1 | Pulse: error-free reception |
| rx_stored | input | 1 | Qualifies `rx_ok`: the frame was stored in a message centre |
| tx_ok | input | 1 | Pulse: error-free, acknowledged transmission |
| autobaud | input | 1 | Auto-baud mode select |
| tec | input | CNT_W | Transmit error count |
| rec | input | CNT_W | Receive error count |
| doze | input | 1 | Doze low-power select |
| pwr_down | input | 1 | Power-down enable |
| err_ie | input | 1 | Error-level interrupt enable |
| stat_ie | input | 1 | Status interrupt enable |
| chan_ie | input | 1 | Channel interrupt enable |
| mod_ie | input | 1 | Module interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| mc_pend | input | 1 | A message-centre interrupt is pending |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Status register read data |
| rx_stat | output | 1 | Sticky receive status |
| tx_stat | output | 1 | Sticky transmit status |
| err_lvl | output | 1 | Error-level flag |
| wake_stat | output | 1 | Wake (low-power) status |
| int_code | output | 2 | Interrupt code |
| irq | output | 1 | Interrupt request level |

## Verification
Directed cases cover the patterns that separate the hidden flag from the visible bits:
- a repeat event while a bit is already set;
- a write of 1 to a bit that is clear, and to a bit that is already set;
- a read that lands in the same cycle as a new event.

Error counts are driven around 127/128 on each counter alone and on both together. This separates the threshold in either direction and shows that the flag is set on both edges. Toggling `doze` and `pwr_down` separates the wake bit's falling edge from its rising edge. Random cycles then mix every input, with `mc_pend` and the enables free. This exposes errors in code priority, in write-versus-set ordering and in `ctl_reset` precedence.

// File: rtl/can_stat_pkg.sv
`timescale 1ns/1ps
package can_stat_pkg;
  typedef enum logic [1:0] {
    IC_NONE   = 2'b00,
    IC_STATUS = 2'b01,
    IC_MSGCTR = 2'b10
  } icode_t;

  localparam int POS_ERR  = 6;
  localparam int POS_WAKE = 5;
  localparam int POS_RX   = 4;
  localparam int POS_TX   = 3;
  localparam int NUM_STICKY = 2;
endpackage

// File: rtl/csi_err_mon.sv
`timescale 1ns/1ps
module csi_err_mon #(
  parameter int CNT_W = 9,
  parameter int LIMIT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  output logic             err_q,
  output logic             err_chg
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  function automatic logic over_limit(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a >= LIMIT_V) || (b >= LIMIT_V);
  endfunction

  logic err_n;
  assign err_n   = over_limit(tec, rec);
  assign err_chg = err_n ^ err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  // R1
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tec >= LIMIT_V || rec >= LIMIT_V) |=> err_q);
  // R1
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tec < LIMIT_V && rec < LIMIT_V) |=> !err_q);
endmodule

// File: rtl/csi_wake_mon.sv
`timescale 1ns/1ps
module csi_wake_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic doze,
  input  logic pwr_down,
  output logic wake_q,
  output logic wake_fall
);
  logic wake_n;
  assign wake_n    = doze | pwr_down;
  assign wake_fall = wake_q & ~wake_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_n;
  end

  // R3
  wake_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doze || pwr_down) |=> wake_q);
  // R3
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!doze && !pwr_down) |=> !wake_q);
endmodule

// File: rtl/csi_sticky_bit.sv
`timescale 1ns/1ps
module csi_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hw_set,
  input  logic wr_en,
  input  logic wr_val,
  output logic bit_q,
  output logic art_set
);
  assign art_set = wr_en & wr_val & ~bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (clr)    bit_q <= 1'b0;
    else if (hw_set) bit_q <= 1'b1;
    else if (wr_en)  bit_q <= wr_val;
  end

  // R6
  hw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q && !clr && !(wr_en && !wr_val)) |=> bit_q);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !clr) |=> bit_q);
endmodule

// File: rtl/can_stat_irq.sv
`timescale 1ns/1ps
module can_stat_irq
  import can_stat_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int LIMIT  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_reset,
  input  logic              rx_ok,
  input  logic              rx_stored,
  input  logic              tx_ok,
  input  logic              autobaud,
  input  logic [CNT_W-1:0]  tec,
  input  logic [CNT_W-1:0]  rec,
  input  logic              doze,
  input  logic              pwr_down,
  input  logic              err_ie,
  input  logic              stat_ie,
  input  logic              chan_ie,
  input  logic              mod_ie,
  input  logic              glob_ie,
  input  logic              mc_pend,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_stat,
  output logic              tx_stat,
  output logic              err_lvl,
  output logic              wake_stat,
  output logic [1:0]        int_code,
  output logic              irq
);
  // Named internal events, index 0 = receive, 1 = transmit
  logic [NUM_STICKY-1:0] hw_set;
  logic [NUM_STICKY-1:0] wr_bits;
  logic [NUM_STICKY-1:0] art_set;
  logic [NUM_STICKY-1:0] stat_q;
  logic err_chg, wake_fall, sc_set, sc_flag;
  icode_t code;

  assign hw_set[0] = rx_ok & (autobaud | rx_stored);
  assign hw_set[1] = tx_ok;
  assign wr_bits   = {reg_wdata[POS_TX], reg_wdata[POS_RX]};

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[DATA_W-1:POS_RX+1], reg_wdata[POS_TX-1:0]};

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    csi_sticky_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctl_reset),
      .hw_set  (hw_set[i]),
      .wr_en   (reg_wr),
      .wr_val  (wr_bits[i]),
      .bit_q   (stat_q[i]),
      .art_set (art_set[i])
    );
  end

  csi_err_mon #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_err (
    .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec),
    .err_q(err_lvl), .err_chg(err_chg)
  );

  csi_wake_mon u_wake (
    .clk(clk), .rst_n(rst_n), .doze(doze), .pwr_down(pwr_down),
    .wake_q(wake_stat), .wake_fall(wake_fall)
  );

  assign sc_set = (stat_ie & ((|hw_set) | (|art_set) | wake_fall))
                | (err_ie & err_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sc_flag <= 1'b0;
    else if (ctl_reset) sc_flag <= 1'b0;
    else if (sc_set)    sc_flag <= 1'b1;
    else if (reg_rd)    sc_flag <= 1'b0;
  end

  always_comb begin
    if (sc_flag)      code = IC_STATUS;
    else if (mc_pend) code = IC_MSGCTR;
    else              code = IC_NONE;
  end

  assign int_code = code;
  assign irq      = (sc_flag & chan_ie & mod_ie & glob_ie) | mc_pend;
  assign rx_stat  = stat_q[0];
  assign tx_stat  = stat_q[1];

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[POS_ERR]  = err_lvl;
    reg_rdata[POS_WAKE] = wake_stat;
    reg_rdata[POS_RX]   = rx_stat;
    reg_rdata[POS_TX]   = tx_stat;
  end

  // R4
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && (autobaud || rx_stored) && !ctl_reset) |=> rx_stat);
  // R5
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && !ctl_reset) |=> tx_stat);
  // R7
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && (autobaud || rx_stored) && stat_ie && !ctl_reset) |=> sc_flag);
  // R2
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_chg && err_ie && !ctl_reset) |=> (int_code == IC_STATUS));
  // R10
  rd_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sc_set && !ctl_reset) |=> sc_flag);
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !sc_set && !ctl_reset) |=> (int_code != IC_STATUS));
  // R13
  crst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (!rx_stat && !tx_stat && !sc_flag));
endmodule

// File: tb/can_stat_irq_tb.sv
`timescale 1ns/1ps
module can_stat_irq_tb;
  localparam int CNT_W = 9;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_reset = 0, rx_ok = 0, rx_stored = 0, tx_ok = 0, autobaud = 0;
  logic [CNT_W-1:0] tec = '0, rec = '0;
  logic doze = 0, pwr_down = 0;
  logic err_ie = 1, stat_ie = 1, chan_ie = 1, mod_ie = 1, glob_ie = 1, mc_pend = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic rx_stat, tx_stat, err_lvl, wake_stat, irq;
  logic [1:0] int_code;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic m_rx = 0, m_tx = 0, m_err = 0, m_wake = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  can_stat_irq #(.CNT_W(CNT_W), .LIMIT(128), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .rx_ok(rx_ok),
    .rx_stored(rx_stored), .tx_ok(tx_ok), .autobaud(autobaud),
    .tec(tec), .rec(rec), .doze(doze), .pwr_down(pwr_down),
    .err_ie(err_ie), .stat_ie(stat_ie), .chan_ie(chan_ie), .mod_ie(mod_ie),
    .glob_ie(glob_ie), .mc_pend(mc_pend), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_stat(rx_stat),
    .tx_stat(tx_stat), .err_lvl(err_lvl), .wake_stat(wake_stat),
    .int_code(int_code), .irq(irq)
  );

  function automatic logic exp_err(input int t, input int r);
    return !(t < 128 && r < 128);
  endfunction

  function automatic int exp_code(input logic flag, input logic mc);
    if (flag) return 1;
    return mc ? 2 : 0;
  endfunction

  function automatic int exp_rdata(input logic e, input logic w, input logic rx, input logic tx);
    return (int'(e) << 6) + (int'(w) << 5) + (int'(rx) << 4) + (int'(tx) << 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R4 R6 R9 R13 rx_stat", int'(rx_stat), int'(m_rx));
    chk("R5 R6 R9 R13 tx_stat", int'(tx_stat), int'(m_tx));
    chk("R1 err_lvl", int'(err_lvl), int'(m_err));
    chk("R3 wake_stat", int'(wake_stat), int'(m_wake));
    chk("R2 R7 R8 R10 int_code", int'(int_code), exp_code(m_flag, mc_pend));
    chk("R11 irq", int'(irq), int'((m_flag & chan_ie & mod_ie & glob_ie) | mc_pend));
    chk("R12 reg_rdata", int'(reg_rdata), exp_rdata(m_err, m_wake, m_rx, m_tx));
  endtask

  // compute next model state from inputs held before the edge, then sample after it
  task automatic step();
    logic hrx, htx, arx, atx, en, wn, wfall, sc;
    logic n_rx, n_tx, n_flag;
    hrx   = rx_ok & (autobaud | rx_stored);
    htx   = tx_ok;
    arx   = reg_wr & reg_wdata[4] & ~m_rx;
    atx   = reg_wr & reg_wdata[3] & ~m_tx;
    en    = exp_err(int'(tec), int'(rec));
    wn    = doze | pwr_down;
    wfall = m_wake & ~wn;
    sc    = (stat_ie & (hrx | htx | arx | atx | wfall)) | (err_ie & (en != m_err));
    n_rx  = hrx | (reg_wr ? reg_wdata[4] : m_rx);
    n_tx  = htx | (reg_wr ? reg_wdata[3] : m_tx);
    n_flag = sc | (m_flag & ~reg_rd);
    if (ctl_reset) begin n_rx = 0; n_tx = 0; n_flag = 0; end
    @(posedge clk);
    #1;
    m_rx = n_rx; m_tx = n_tx; m_flag = n_flag; m_err = en; m_wake = wn;
    compare();
  endtask

  task automatic idle();
    ctl_reset = 0; rx_ok = 0; rx_stored = 0; tx_ok = 0;
    reg_wr = 0; reg_rd = 0; reg_wdata = '0;
  endtask

  initial begin
    #250000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare();                 // reset state, R13
    rst_n = 1;

    // R4: unstored reception without auto-baud leaves rx clear
    rx_ok = 1; step(); idle();
    // R4: stored reception sets rx and flag
    rx_ok = 1; rx_stored = 1; step(); idle();
    // R8: read clears flag, code falls to message centre then none
    reg_rd = 1; mc_pend = 1; step(); idle(); step();
    mc_pend = 0; step();
    // R7: repeat reception while rx already 1 still raises flag (auto-baud, unstored)
    autobaud = 1; rx_ok = 1; step(); idle(); autobaud = 0;
    // R10: read in the same cycle as a transmit event keeps flag
    reg_rd = 1; tx_ok = 1; step(); idle();
    reg_rd = 1; step(); idle();
    // R9: write 1 to bits already 1 raises nothing
    reg_wr = 1; reg_wdata = 8'h18; step(); idle();
    // R6: write 0 clears, and hardware set wins over write 0
    reg_wr = 1; reg_wdata = 8'h00; tx_ok = 1; step(); idle();
    reg_rd = 1; step(); idle();
    // R9: write 1 to clear rx bit gives artificial interrupt; R11 gated by chain
    reg_wr = 1; reg_wdata = 8'h10; step(); idle();
    glob_ie = 0; step(); glob_ie = 1; step();
    reg_rd = 1; step(); idle();
    // R1 R2: error count threshold both directions, each counter
    tec = 9'd127; step(); tec = 9'd128; step(); reg_rd = 1; step(); idle();
    tec = 9'd127; step(); rec = 9'd300; step(); tec = 9'd200; rec = 9'd0; step();
    tec = 9'd0; step();
    reg_rd = 1; step(); idle();
    // R3: wake rise gives no flag, fall gives flag
    doze = 1; step(); pwr_down = 1; doze = 0; step(); pwr_down = 0; step();
    reg_rd = 1; step(); idle();
    // R13: controller reset beats simultaneous events
    rx_ok = 1; rx_stored = 1; tx_ok = 1; ctl_reset = 1; step(); idle();
    tx_ok = 1; step(); idle(); ctl_reset = 1; step(); idle();

    // constrained random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      ctl_reset = ($urandom_range(0, 49) == 0);
      rx_ok     = ($urandom_range(0, 3) == 0);
      rx_stored = $urandom_range(0, 1) != 0;
      tx_ok     = ($urandom_range(0, 3) == 0);
      autobaud  = ($urandom_range(0, 3) == 0);
      tec       = CNT_W'($urandom_range(120, 136));
      rec       = ($urandom_range(0, 1) != 0) ? CNT_W'($urandom_range(0, 130)) : '0;
      doze      = ($urandom_range(0, 4) == 0);
      pwr_down  = ($urandom_range(0, 6) == 0);
      err_ie    = ($urandom_range(0, 3) != 0);
      stat_ie   = ($urandom_range(0, 3) != 0);
      chan_ie   = ($urandom_range(0, 5) != 0);
      mod_ie    = ($urandom_range(0, 5) != 0);
      glob_ie   = ($urandom_range(0, 5) != 0);
      mc_pend   = ($urandom_range(0, 4) == 0);
      reg_wr    = ($urandom_range(0, 7) == 0);
      reg_rd    = ($urandom_range(0, 3) == 0);
      reg_wdata = DW'($urandom_range(0, 255));
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule